// File: doc/BRIEF.md
# Platform System Control Register Bank

This block is a byte-wide bank of control and identification registers that sits on a simple port-addressed I/O request bus. Apart from a single stand-alone port that drives the platform's soft-reset line, every register lives in a contiguous window of ports. Software uses the bank to do five things: pulse the reset line, light the disk-activity indicator, send lock-toggle strobes to a battery-backed memory, strobe a cache invalidate, and set a 4-bit system-control field. It also chooses between the dense and the sparse decoding of the I/O address space. A neighbouring address bridge consumes that choice.

Reads return fixed identification bytes, the stored state, or 0xFF for any port that has no register behind it. Requests arrive on a valid/ready channel. A read produces one response beat on a separate valid/ready channel. A write produces no response. The response register holds one entry. While a response waits for `rsp_ready`, `req_ready` stays low and no new request is taken. When the response leaves in a cycle, a new request can be taken in that same cycle.

Top module: `sysctl_bank`

## Requirements
- R1: After reset, `soft_reset`, `hardfile_on`, `sys_ctrl`, `map_sparse`, all three pulse outputs and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A write to port 0x092 sets `soft_reset` to bit 0 of the data. The new value is visible in the cycle after the write is accepted.
- R3: A write to port 0x81C stores the data AND 0x0F into `sys_ctrl`. A read of 0x81C returns that value zero-extended.
- R4: A write to port 0x850 stores data bit 0 into `map_sparse`. A read of 0x850 returns 0x00 or 0x01.
- R5: The identification ports return fixed bytes: 0x800 returns 0xEF, 0x802 returns 0xAD, 0x803 returns 0xE0 and 0x80C returns 0x39. Writes to these ports change nothing.
- R6: A read of port 0x81D returns 0x03, which reports that no second-level cache is present.
- R7: A write to port 0x808 sets `hardfile_on` to data bit 0. A read of 0x808 returns that bit.
- R8: A write to port 0x810 raises `nvlock_a_pulse` for exactly one cycle, and a write to port 0x811 does the same for `nvlock_b_pulse`. Each pulse appears in the cycle after acceptance. Reads of either port return 0xFF.
- R9: A write to port 0x814 raises `cache_inv_pulse` for exactly one cycle and touches no stored state.
- R10: A read of any unassigned port returns 0xFF. This covers 0x801, ports outside the window 0x800 to 0x851, and port 0x852. A write to such a port changes no output.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays stable and `req_ready` is low. A response is produced only for an accepted read.
- R12: A read of port 0x092 returns the current `soft_reset` value in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The bank accepts the request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Port address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data is offered |
| rsp_ready | input | 1 | The consumer takes the read data |
| rsp_data | output | 8 | Read data |
| soft_reset | output | 1 | Platform soft-reset request |
| hardfile_on | output | 1 | Disk-activity light state |
| nvlock_a_pulse | output | 1 | One-cycle lock toggle, first password register |
| nvlock_b_pulse | output | 1 | One-cycle lock toggle, second password register |
| cache_inv_pulse | output | 1 | One-cycle cache invalidate strobe |
| sys_ctrl | output | 4 | System-control field |
| map_sparse | output | 1 | I/O map type, exported to the address bridge |

## Verification
The bench writes the reset port, the control field and the map bit with data whose upper bits are set. A bank that stored the whole byte would then read back the wrong value, and one that tested the wrong bit would leave the outputs wrong. Pulse outputs are sampled in the cycle after the write and again one cycle later, so a strobe that stuck high or that never fired is caught. The bench writes the identification ports and the unassigned ports, then reads them back and checks the outputs. This exposes a decode that aliases a neighbour or leaks into stored state. It also reads port 0x852, one past the window, to catch an off-by-one window bound. Finally it stalls the response channel and queues a second read behind the first, which exposes a bank that overwrites or drops a pending response.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 4;
  localparam int N_PULSE = 3;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RST, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_EXTF,
    SEL_HARDFILE, SEL_LOCK_A, SEL_LOCK_B, SEL_CINV, SEL_SYSCTL,
    SEL_L2STAT, SEL_MAP
  } sel_e;

  localparam logic [BYTE_W-1:0] ID_CPUCFG  = 8'hEF;
  localparam logic [BYTE_W-1:0] ID_FEAT    = 8'hAD;
  localparam logic [BYTE_W-1:0] ID_STAT    = 8'hE0;
  localparam logic [BYTE_W-1:0] ID_EXTF    = 8'h39;
  localparam logic [BYTE_W-1:0] ID_L2STAT  = 8'h03;
  localparam logic [BYTE_W-1:0] RD_EMPTY   = 8'hFF;

  // selector that drives pulse output i
  function automatic sel_e pulse_sel(input int i);
    case (i)
      0:       return SEL_LOCK_A;
      1:       return SEL_LOCK_B;
      default: return SEL_CINV;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PORT   = 16'h0092,
  parameter logic [ADDR_W-1:0] BANK_BASE    = 16'h0800,
  parameter logic [ADDR_W-1:0] BANK_SPAN    = 16'h0052,
  parameter logic [ADDR_W-1:0] OFS_CPUCFG   = 16'h0000,
  parameter logic [ADDR_W-1:0] OFS_FEAT     = 16'h0002,
  parameter logic [ADDR_W-1:0] OFS_STAT     = 16'h0003,
  parameter logic [ADDR_W-1:0] OFS_EXTF     = 16'h000C,
  parameter logic [ADDR_W-1:0] OFS_HARDFILE = 16'h0008,
  parameter logic [ADDR_W-1:0] OFS_LOCK_A   = 16'h0010,
  parameter logic [ADDR_W-1:0] OFS_LOCK_B   = 16'h0011,
  parameter logic [ADDR_W-1:0] OFS_CINV     = 16'h0014,
  parameter logic [ADDR_W-1:0] OFS_SYSCTL   = 16'h001C,
  parameter logic [ADDR_W-1:0] OFS_L2STAT   = 16'h001D,
  parameter logic [ADDR_W-1:0] OFS_MAP      = 16'h0050
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  logic [ADDR_W-1:0] ofs;
  logic              in_bank;

  always_comb begin
    ofs     = addr - BANK_BASE;
    in_bank = (addr >= BANK_BASE) && (ofs < BANK_SPAN);
    sel     = SEL_NONE;
    if (addr == RESET_PORT)          sel = SEL_RST;
    else if (in_bank) begin
      if      (ofs == OFS_CPUCFG)    sel = SEL_CPUCFG;
      else if (ofs == OFS_FEAT)      sel = SEL_FEAT;
      else if (ofs == OFS_STAT)      sel = SEL_STAT;
      else if (ofs == OFS_EXTF)      sel = SEL_EXTF;
      else if (ofs == OFS_HARDFILE)  sel = SEL_HARDFILE;
      else if (ofs == OFS_LOCK_A)    sel = SEL_LOCK_A;
      else if (ofs == OFS_LOCK_B)    sel = SEL_LOCK_B;
      else if (ofs == OFS_CINV)      sel = SEL_CINV;
      else if (ofs == OFS_SYSCTL)    sel = SEL_SYSCTL;
      else if (ofs == OFS_L2STAT)    sel = SEL_L2STAT;
      else if (ofs == OFS_MAP)       sel = SEL_MAP;
    end
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  sel_e              sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              soft_reset,
  output logic              hardfile_on,
  output logic [CTRL_W-1:0] sys_ctrl,
  output logic              map_sparse,
  output logic [N_PULSE-1:0] pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_reset  <= 1'b0;
      hardfile_on <= 1'b0;
      sys_ctrl    <= '0;
      map_sparse  <= 1'b0;
    end else if (wr_fire) begin
      case (sel)
        SEL_RST:      soft_reset  <= wdata[0];
        SEL_HARDFILE: hardfile_on <= wdata[0];
        SEL_SYSCTL:   sys_ctrl    <= wdata[CTRL_W-1:0];
        SEL_MAP:      map_sparse  <= wdata[0];
        default: ;
      endcase
    end
  end

  // one strobe flop per write-only pulse register
  for (genvar i = 0; i < N_PULSE; i++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= wr_fire && (sel == pulse_sel(i));
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  sel_e              sel,
  input  logic              soft_reset,
  input  logic              hardfile_on,
  input  logic [CTRL_W-1:0] sys_ctrl,
  input  logic              map_sparse,
  output logic [BYTE_W-1:0] rd_byte
);
  always_comb begin
    case (sel)
      SEL_RST:      rd_byte = BYTE_W'(soft_reset);
      SEL_CPUCFG:   rd_byte = ID_CPUCFG;
      SEL_FEAT:     rd_byte = ID_FEAT;
      SEL_STAT:     rd_byte = ID_STAT;
      SEL_EXTF:     rd_byte = ID_EXTF;
      SEL_HARDFILE: rd_byte = BYTE_W'(hardfile_on);
      SEL_SYSCTL:   rd_byte = BYTE_W'(sys_ctrl);
      SEL_L2STAT:   rd_byte = ID_L2STAT;
      SEL_MAP:      rd_byte = BYTE_W'(map_sparse);
      default:      rd_byte = RD_EMPTY;
    endcase
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PORT   = 16'h0092,
  parameter logic [ADDR_W-1:0] BANK_BASE    = 16'h0800,
  parameter logic [ADDR_W-1:0] BANK_SPAN    = 16'h0052,
  parameter logic [ADDR_W-1:0] OFS_CPUCFG   = 16'h0000,
  parameter logic [ADDR_W-1:0] OFS_FEAT     = 16'h0002,
  parameter logic [ADDR_W-1:0] OFS_STAT     = 16'h0003,
  parameter logic [ADDR_W-1:0] OFS_EXTF     = 16'h000C,
  parameter logic [ADDR_W-1:0] OFS_HARDFILE = 16'h0008,
  parameter logic [ADDR_W-1:0] OFS_LOCK_A   = 16'h0010,
  parameter logic [ADDR_W-1:0] OFS_LOCK_B   = 16'h0011,
  parameter logic [ADDR_W-1:0] OFS_CINV     = 16'h0014,
  parameter logic [ADDR_W-1:0] OFS_SYSCTL   = 16'h001C,
  parameter logic [ADDR_W-1:0] OFS_L2STAT   = 16'h001D,
  parameter logic [ADDR_W-1:0] OFS_MAP      = 16'h0050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              soft_reset,
  output logic              hardfile_on,
  output logic              nvlock_a_pulse,
  output logic              nvlock_b_pulse,
  output logic              cache_inv_pulse,
  output logic [3:0]        sys_ctrl,
  output logic              map_sparse
);
  sel_e              sel;
  logic              accept, wr_fire, rd_fire;
  logic [BYTE_W-1:0] rd_byte;
  logic [N_PULSE-1:0] pulse;

  // single-entry response slot: a new request enters when it is free or draining
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_fire   = accept && req_write;
  assign rd_fire   = accept && !req_write;

  sysctl_decode #(
    .ADDR_W(ADDR_W), .RESET_PORT(RESET_PORT), .BANK_BASE(BANK_BASE),
    .BANK_SPAN(BANK_SPAN), .OFS_CPUCFG(OFS_CPUCFG), .OFS_FEAT(OFS_FEAT),
    .OFS_STAT(OFS_STAT), .OFS_EXTF(OFS_EXTF), .OFS_HARDFILE(OFS_HARDFILE),
    .OFS_LOCK_A(OFS_LOCK_A), .OFS_LOCK_B(OFS_LOCK_B), .OFS_CINV(OFS_CINV),
    .OFS_SYSCTL(OFS_SYSCTL), .OFS_L2STAT(OFS_L2STAT), .OFS_MAP(OFS_MAP)
  ) u_decode (
    .addr(req_addr),
    .sel (sel)
  );

  sysctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .sel        (sel),
    .wdata      (req_wdata),
    .soft_reset (soft_reset),
    .hardfile_on(hardfile_on),
    .sys_ctrl   (sys_ctrl),
    .map_sparse (map_sparse),
    .pulse      (pulse)
  );

  sysctl_rdmux u_rdmux (
    .sel        (sel),
    .soft_reset (soft_reset),
    .hardfile_on(hardfile_on),
    .sys_ctrl   (sys_ctrl),
    .map_sparse (map_sparse),
    .rd_byte    (rd_byte)
  );

  assign nvlock_a_pulse  = pulse[0];
  assign nvlock_b_pulse  = pulse[1];
  assign cache_inv_pulse = pulse[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PORT = 16'h0092,
  parameter logic [ADDR_W-1:0] BANK_BASE  = 16'h0800,
  parameter logic [ADDR_W-1:0] OFS_SYSCTL = 16'h001C,
  parameter logic [ADDR_W-1:0] OFS_LOCK_A = 16'h0010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic              soft_reset,
  input logic              nvlock_a_pulse,
  input logic [3:0]        sys_ctrl
);
  logic wr_acc, rd_acc;
  assign wr_acc = req_valid && req_ready && req_write;
  assign rd_acc = req_valid && req_ready && !req_write;

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_rsp_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(rd_acc));

  assert_ctrl_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sys_ctrl) |-> $past(wr_acc && req_addr == BANK_BASE + OFS_SYSCTL));

  assert_lock_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nvlock_a_pulse |-> $past(wr_acc && req_addr == BANK_BASE + OFS_LOCK_A));

  assert_reset_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_reset) |-> $past(wr_acc && req_addr == RESET_PORT && req_wdata[0]));
endmodule

bind sysctl_bank sysctl_bank_chk #(
  .ADDR_W(ADDR_W), .RESET_PORT(RESET_PORT), .BANK_BASE(BANK_BASE),
  .OFS_SYSCTL(OFS_SYSCTL), .OFS_LOCK_A(OFS_LOCK_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .soft_reset(soft_reset), .nvlock_a_pulse(nvlock_a_pulse), .sys_ctrl(sys_ctrl)
);

// File: tb/sysctl_bank_test.sv
module sysctl_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic        soft_reset, hardfile_on, nvlock_a_pulse, nvlock_b_pulse, cache_inv_pulse;
  logic [3:0]  sys_ctrl;
  logic        map_sparse;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  sysctl_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .soft_reset(soft_reset), .hardfile_on(hardfile_on),
    .nvlock_a_pulse(nvlock_a_pulse), .nvlock_b_pulse(nvlock_b_pulse),
    .cache_inv_pulse(cache_inv_pulse), .sys_ctrl(sys_ctrl), .map_sparse(map_sparse)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // returns at the falling edge after the accepting edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_data : 8'hXX;
  endtask

  task automatic t_reset();
    check("R1 soft_reset", 8'(soft_reset), 8'h00);
    check("R1 hardfile", 8'(hardfile_on), 8'h00);
    check("R1 sys_ctrl", 8'(sys_ctrl), 8'h00);
    check("R1 map", 8'(map_sparse), 8'h00);
    check("R1 pulses", 8'({nvlock_a_pulse, nvlock_b_pulse, cache_inv_pulse}), 8'h00);
    check("R1 rsp_valid", 8'(rsp_valid), 8'h00);
    check("R1 req_ready", 8'(req_ready), 8'h01);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    wr(16'h0092, 8'h01);
    check("R2 set", 8'(soft_reset), 8'h01);
    rd(16'h0092, d); check("R12 read set", d, 8'h01);
    wr(16'h0092, 8'hFE);
    check("R2 clear", 8'(soft_reset), 8'h00);
    rd(16'h0092, d); check("R12 read clear", d, 8'h00);
  endtask

  task automatic t_sysctl();
    logic [7:0] d;
    wr(16'h081C, 8'hA7);
    check("R3 field", 8'(sys_ctrl), 8'h07);
    rd(16'h081C, d); check("R3 readback", d, 8'h07);
    wr(16'h081C, 8'hF0);
    check("R3 upper ignored", 8'(sys_ctrl), 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr(16'h0850, 8'h03);
    check("R4 set", 8'(map_sparse), 8'h01);
    rd(16'h0850, d); check("R4 readback", d, 8'h01);
    wr(16'h0850, 8'h02);
    check("R4 clear", 8'(map_sparse), 8'h00);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    rd(16'h0800, d); check("R5 cpucfg", d, 8'hEF);
    rd(16'h0802, d); check("R5 feature", d, 8'hAD);
    rd(16'h0803, d); check("R5 status", d, 8'hE0);
    rd(16'h080C, d); check("R5 extfeat", d, 8'h39);
    wr(16'h0800, 8'h00);
    rd(16'h0800, d); check("R5 write ignored", d, 8'hEF);
    rd(16'h081D, d); check("R6 l2 status", d, 8'h03);
  endtask

  task automatic t_hardfile();
    logic [7:0] d;
    wr(16'h0808, 8'h01);
    check("R7 on", 8'(hardfile_on), 8'h01);
    rd(16'h0808, d); check("R7 readback", d, 8'h01);
    wr(16'h0808, 8'hFE);
    check("R7 off", 8'(hardfile_on), 8'h00);
  endtask

  task automatic t_pulses();
    logic [7:0] d;
    wr(16'h0810, 8'h00);
    check("R8 lock a fires", 8'({nvlock_a_pulse, nvlock_b_pulse}), 8'h02);
    @(negedge clk);
    check("R8 lock a one cycle", 8'(nvlock_a_pulse), 8'h00);
    wr(16'h0811, 8'h00);
    check("R8 lock b fires", 8'({nvlock_a_pulse, nvlock_b_pulse}), 8'h01);
    @(negedge clk);
    check("R8 lock b one cycle", 8'(nvlock_b_pulse), 8'h00);
    rd(16'h0810, d); check("R8 read lock", d, 8'hFF);
    wr(16'h0814, 8'h5A);
    check("R9 inv fires", 8'(cache_inv_pulse), 8'h01);
    check("R9 state untouched", 8'({hardfile_on, map_sparse, sys_ctrl}), 8'h00);
    @(negedge clk);
    check("R9 inv one cycle", 8'(cache_inv_pulse), 8'h00);
  endtask

  task automatic t_unassigned();
    logic [7:0] d;
    rd(16'h0801, d); check("R10 hole", d, 8'hFF);
    rd(16'h0300, d); check("R10 outside", d, 8'hFF);
    rd(16'h0852, d); check("R10 past end", d, 8'hFF);
    wr(16'h0801, 8'hFF);
    wr(16'h0852, 8'hFF);
    wr(16'h091C, 8'hFF);
    check("R10 writes ignored",
          8'({soft_reset, hardfile_on, map_sparse, sys_ctrl}), 8'h00);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0800;
    @(posedge clk); @(negedge clk);
    req_addr = 16'h081D;
    check("R11 stall ready", 8'(req_ready), 8'h00);
    repeat (2) @(negedge clk);
    check("R11 held data", rsp_data, 8'hEF);
    check("R11 held valid", 8'(rsp_valid), 8'h01);
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R11 next read", rsp_data, 8'h03);
    @(negedge clk);
    check("R11 drained", 8'(rsp_valid), 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_soft_reset();
    t_sysctl();
    t_map();
    t_ids();
    t_hardfile();
    t_pulses();
    t_unassigned();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule